// File: doc/BRIEF.md
# Multi-Pattern Frame Matcher

This block watches a received frame, delivered as a stream of 32-bit dwords, and checks it against up to eight patterns held in a shared table of 40-bit entries. Two header entries at addresses 0 and 1 hold one enable bit per pattern and an 8-bit start address for each pattern. Each pattern is a run of consecutive entries. Every entry carries four data bytes, a per-byte compare mask, a count of incoming dwords to pass over before the compare, and a flag that closes the pattern.

Eight independent lanes walk their own patterns in parallel. A lane is loaded from the header when a frame starts. It then consumes each valid dword, either skipping it or comparing it, and ends in a hit or a miss. When the frame ends, the block registers the set of lanes that hit into an 8-bit match vector and raises a one-cycle done strobe. The table is loaded through a simple write port. The table has no reset, so software must load it before frames arrive.

Top module: `pm_frame_matcher`

## Requirements
- R1: While reset is applied, and after it is released until the first frame end, match_o is all zeros and done_o is low.
- R2: done_o is high for exactly one cycle: the cycle after eof_i is sampled high. match_o takes its new value in that same cycle and holds it until the next sof_i.
- R3: The header is read when sof_i is sampled. Entry 0 bits 7:0 are the enables, with bit n enabling pattern n. The start address of pattern k (k = 0..3) is in entry 0 bits [8k+15:8k+8]. The start address of pattern k (k = 4..7) is in entry 1 bits [8(k-4)+15:8(k-4)+8].
- R4: In a pattern entry, bits 39:8 hold data. Data byte n (bits [8n+15:8n+8]) is compared with data_i bits [8n+7:8n]. Entries are used in ascending address order from the start address. A pattern hits when every entry, up to and including the one whose bit 7 is set, compares equal before eof_i.
- R5: Entry bits 3:0 are byte enables for the compare. Bit n at 0 removes data byte n from the compare, and a mask of 0 accepts any dword.
- R6: Entry bits 6:4 give a count of 0 to 7 valid dwords that are consumed, without being compared, before the dword that is compared with this entry.
- R7: A compare that fails ends the pattern for the current frame. Later dwords cannot bring it back.
- R8: A pattern that has not reached its closing entry when eof_i arrives does not match.
- R9: A pattern whose enable bit is 0 never sets its match bit.
- R10: Lanes are independent, so several match bits may be set for the same frame.
- R11: Cycles with dv_i low, and dwords that arrive after a pattern's closing entry, do not affect that pattern's result.
- R12: sof_i clears match_o in the next cycle and restarts every lane. A dword whose dv_i is high in a cycle that also carries sof_i or eof_i is not consumed.
- R13: A pattern does not match if its start address is below 2 or not below the table depth, or if its run of entries reaches the last table entry without a closing flag.
- R14: A write through the write port is used by any frame that starts in a later cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | AW (6) | Table write address |
| wr_data_i | input | 40 | Table write data |
| sof_i | input | 1 | Frame start strobe |
| eof_i | input | 1 | Frame end strobe |
| dv_i | input | 1 | Dword valid |
| data_i | input | 32 | Frame dword, byte n in bits [8n+7:8n] |
| match_o | output | 8 | Bit n set when pattern n matched the last frame |
| done_o | output | 1 | One-cycle strobe marking a new match_o |

## Verification
The match vector and done strobe are due exactly one cycle after the cycle that carries eof_i. The clear caused by sof_i is also due one cycle later. The bench drives strobes on the falling edge and samples one falling edge after that, so exactly one rising edge separates the stimulus from the check. A following falling edge confirms that done_o has dropped and that match_o holds. Table writes are made at least one cycle before the sof_i of the frame that relies on them, matching the one-cycle write latency.

// File: rtl/pm_match_pkg.sv
package pm_match_pkg;

    localparam int NUM_PAT      = 8;
    localparam int DWORD_W      = 32;
    localparam int NUM_BYTES    = DWORD_W / 8;
    localparam int CTRL_W       = 8;
    localparam int ENTRY_W      = DWORD_W + CTRL_W;
    localparam int PTR_W        = 8;
    localparam int SKIP_W       = 3;
    localparam int HDR_ENTRIES  = 2;
    localparam int PTRS_PER_HDR = NUM_PAT / HDR_ENTRIES;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_RUN,
        LN_HIT,
        LN_MISS
    } lane_st_e;

    typedef struct packed {
        logic                 eop;
        logic [SKIP_W-1:0]    skip;
        logic [NUM_BYTES-1:0] mask;
    } ctrl_t;

    typedef struct packed {
        logic [DWORD_W-1:0] pat;
        ctrl_t              ctrl;
    } entry_t;

endpackage

// File: rtl/pm_entry_store.sv
module pm_entry_store
    import pm_match_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                          clk_i,
    input  logic                          wr_en_i,
    input  logic [AW-1:0]                 wr_addr_i,
    input  entry_t                        wr_data_i,
    input  logic [NUM_PAT-1:0][AW-1:0]    rd_addr_i,
    output entry_t [NUM_PAT-1:0]          rd_data_o,
    output logic [NUM_PAT-1:0]            en_o,
    output logic [NUM_PAT-1:0][PTR_W-1:0] start_o
);

    // Table storage: no reset, contents are owned by software.
    entry_t mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign en_o = mem_q[0][NUM_PAT-1:0];

    for (genvar k = 0; k < NUM_PAT; k++) begin : g_port
        localparam int HDR_IDX  = k / PTRS_PER_HDR;
        localparam int BYTE_IDX = (k % PTRS_PER_HDR) + 1;

        assign start_o[k]   = mem_q[HDR_IDX][8*BYTE_IDX +: PTR_W];
        assign rd_data_o[k] = mem_q[rd_addr_i[k]];
    end

endmodule

// File: rtl/pm_lane.sv
module pm_lane
    import pm_match_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sof_i,
    input  logic               eof_i,
    input  logic               dv_i,
    input  logic [DWORD_W-1:0] data_i,
    input  logic               en_i,
    input  logic [PTR_W-1:0]   start_i,
    input  entry_t             entry_i,
    output logic [AW-1:0]      rd_addr_o,
    output logic               hit_o,
    output logic               miss_o
);

    typedef struct packed {
        lane_st_e          st;
        logic [AW-1:0]     ptr;
        logic [SKIP_W-1:0] skip;
    } lane_t;

    lane_t                cur_q;
    lane_t                nxt_d;
    logic [NUM_BYTES-1:0] byte_ok;
    logic                 entry_eq;
    logic                 ptr_bad;
    logic                 at_last;

    // Per-byte compare, masked bytes always agree.
    always_comb begin
        for (int b = 0; b < NUM_BYTES; b++) begin
            byte_ok[b] = !entry_i.ctrl.mask[b]
                       || (data_i[8*b +: 8] == entry_i.pat[8*b +: 8]);
        end
    end

    assign entry_eq = &byte_ok;
    assign ptr_bad  = (32'(start_i) < 32'(HDR_ENTRIES))
                   || (32'(start_i) >= 32'(DEPTH));
    assign at_last  = (cur_q.ptr == AW'(DEPTH - 1));

    always_comb begin
        nxt_d = cur_q;
        if (eof_i) begin
            nxt_d.st = LN_IDLE;
        end else if (sof_i) begin
            nxt_d.ptr  = start_i[AW-1:0];
            nxt_d.skip = '0;
            if (!en_i) begin
                nxt_d.st = LN_IDLE;
            end else if (ptr_bad) begin
                nxt_d.st = LN_MISS;
            end else begin
                nxt_d.st = LN_RUN;
            end
        end else if (dv_i && (cur_q.st == LN_RUN)) begin
            if (cur_q.skip < entry_i.ctrl.skip) begin
                nxt_d.skip = cur_q.skip + SKIP_W'(1);
            end else if (!entry_eq) begin
                nxt_d.st = LN_MISS;
            end else if (entry_i.ctrl.eop) begin
                nxt_d.st = LN_HIT;
            end else if (at_last) begin
                nxt_d.st = LN_MISS;
            end else begin
                nxt_d.ptr  = cur_q.ptr + AW'(1);
                nxt_d.skip = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '{st: LN_IDLE, ptr: '0, skip: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rd_addr_o = cur_q.ptr;
    assign hit_o     = (cur_q.st == LN_HIT);
    assign miss_o    = (cur_q.st == LN_MISS);

endmodule

// File: rtl/pm_frame_matcher.sv
module pm_frame_matcher
    import pm_match_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [AW-1:0]      wr_addr_i,
    input  logic [ENTRY_W-1:0] wr_data_i,
    input  logic               sof_i,
    input  logic               eof_i,
    input  logic               dv_i,
    input  logic [DWORD_W-1:0] data_i,
    output logic [NUM_PAT-1:0] match_o,
    output logic               done_o
);

    typedef struct packed {
        logic [NUM_PAT-1:0] match;
        logic               done;
    } res_t;

    logic [NUM_PAT-1:0]            en_w;
    logic [NUM_PAT-1:0][PTR_W-1:0] start_w;
    logic [NUM_PAT-1:0][AW-1:0]    rd_addr_w;
    entry_t [NUM_PAT-1:0]          rd_data_w;
    logic [NUM_PAT-1:0]            hit_vec;
    logic [NUM_PAT-1:0]            miss_vec;
    res_t                          res_q;
    res_t                          res_d;

    pm_entry_store #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) store_i (
        .clk_i     (clk_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (entry_t'(wr_data_i)),
        .rd_addr_i (rd_addr_w),
        .rd_data_o (rd_data_w),
        .en_o      (en_w),
        .start_o   (start_w)
    );

    for (genvar k = 0; k < NUM_PAT; k++) begin : g_lane
        pm_lane #(
            .DEPTH (DEPTH),
            .AW    (AW)
        ) lane_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .sof_i     (sof_i),
            .eof_i     (eof_i),
            .dv_i      (dv_i),
            .data_i    (data_i),
            .en_i      (en_w[k]),
            .start_i   (start_w[k]),
            .entry_i   (rd_data_w[k]),
            .rd_addr_o (rd_addr_w[k]),
            .hit_o     (hit_vec[k]),
            .miss_o    (miss_vec[k])
        );
    end

    always_comb begin
        res_d      = res_q;
        res_d.done = eof_i;
        if (eof_i) begin
            res_d.match = hit_vec;
        end else if (sof_i) begin
            res_d.match = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign match_o = res_q.match;
    assign done_o  = res_q.done;

endmodule

module pm_frame_matcher_chk
    import pm_match_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic               sof_i,
    input logic               eof_i,
    input logic [NUM_PAT-1:0] match_o,
    input logic               done_o,
    input logic [NUM_PAT-1:0] hit_vec,
    input logic [NUM_PAT-1:0] miss_vec
);

    AST_DONE_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eof_i |=> done_o); // R2

    AST_DONE_NEEDS_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(eof_i)); // R2

    AST_MATCH_FROM_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eof_i |=> (match_o == $past(hit_vec))); // R4

    AST_SOF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sof_i && !eof_i) |=> (match_o == '0)); // R12

    AST_MATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sof_i && !eof_i) |=> $stable(match_o)); // R2

    AST_MISS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sof_i && !eof_i) |=> (($past(miss_vec) & ~miss_vec) == '0)); // R7

endmodule

bind pm_frame_matcher pm_frame_matcher_chk chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sof_i    (sof_i),
    .eof_i    (eof_i),
    .match_o  (match_o),
    .done_o   (done_o),
    .hit_vec  (hit_vec),
    .miss_vec (miss_vec)
);

// File: tb/pm_frame_matcher_tb_top.sv
module pm_frame_matcher_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [39:0] wr_data = '0;
    logic        sof = 1'b0;
    logic        eof = 1'b0;
    logic        dv = 1'b0;
    logic [31:0] data = '0;
    logic [7:0]  match;
    logic        done;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pm_frame_matcher dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .sof_i     (sof),
        .eof_i     (eof),
        .dv_i      (dv),
        .data_i    (data),
        .match_o   (match),
        .done_o    (done)
    );

    typedef struct packed {
        logic [2:0]  n;
        logic [31:0] d0;
        logic [31:0] d1;
        logic [31:0] d2;
        logic [7:0]  exp;
    } vec_t;

    // Frames against the loaded table; expected vectors worked out by hand.
    localparam vec_t VECS [7] = '{
        '{3'd3, 32'hA1A2A3A4, 32'h00000000, 32'h12345678, 8'h01},
        '{3'd3, 32'h11112222, 32'h55FFFFFF, 32'hDEAD3344, 8'h06},
        '{3'd3, 32'h11112222, 32'h99999999, 32'hA1A2A3A4, 8'h28},
        '{3'd3, 32'hA1A2A3A4, 32'h55000000, 32'hA1A2A3A4, 8'h0D},
        '{3'd1, 32'h11112222, 32'h00000000, 32'h00000000, 8'h00},
        '{3'd2, 32'hA1A2A3A4, 32'hA1A2A3A4, 32'h00000000, 8'h01},
        '{3'd3, 32'h11112222, 32'h00000000, 32'hFFFF3344, 8'h02}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [39:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Ends on the falling edge right after the one rising edge that sees eof.
    task automatic send_frame(input int n, input logic [4:0][31:0] w, input bit gaps);
        @(negedge clk);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        for (int i = 0; i < n; i++) begin
            dv = 1'b1; data = w[i];
            @(negedge clk);
            if (gaps) begin
                dv = 1'b0; data = 32'h0BAD0BAD;
                @(negedge clk);
            end
        end
        dv = 1'b0;
        eof = 1'b1;
        @(negedge clk);
        eof = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 match in reset", 32'(match), 32'h0);
        chk("R1 done in reset", 32'(done), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 match after reset", 32'(match), 32'h0);
        chk("R1 done after reset", 32'(done), 32'h0);

        // R3 header: enables EF, pointers P0..P3 = 2,3,5,7 ; P4..P7 = 2,8,1,62
        wr(6'd0,  40'h07_05_03_02_EF);
        wr(6'd1,  40'h3E_01_08_02_00);
        wr(6'd2,  40'hA1A2A3A4_8F);
        wr(6'd3,  40'h11112222_0F);
        wr(6'd4,  40'hFFFF3344_93);
        wr(6'd5,  40'h00000000_00);
        wr(6'd6,  40'h55ABCDEF_88);
        wr(6'd7,  40'hA1A2A3A4_AF);
        wr(6'd8,  40'h11112222_0F);
        wr(6'd9,  40'h99999999_8F);
        wr(6'd62, 40'hA1A2A3A4_0F);
        wr(6'd63, 40'h00000000_0F);

        // Table walk: R4 R5 R6 R8 R9 R10 R13 together
        for (int v = 0; v < 7; v++) begin
            send_frame(int'(VECS[v].n), {32'h0, 32'h0, VECS[v].d2, VECS[v].d1, VECS[v].d0}, 1'b0);
            chk($sformatf("R10 vector %0d match", v), 32'(match), 32'(VECS[v].exp));
            chk($sformatf("R2 vector %0d done", v), 32'(done), 32'h1);
        end

        // R2: strobe lasts one cycle, vector holds
        send_frame(3, {32'h0, 32'h0, 32'h12345678, 32'h00000000, 32'hA1A2A3A4}, 1'b0);
        chk("R2 done high", 32'(done), 32'h1);
        @(negedge clk);
        chk("R2 done drops", 32'(done), 32'h0);
        chk("R2 match holds", 32'(match), 32'h01);

        // R12: sof clears the vector one cycle later
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        chk("R12 sof clears match", 32'(match), 32'h0);
        eof = 1'b1;
        @(negedge clk);
        eof = 1'b0;
        chk("R8 empty frame", 32'(match), 32'h0);

        // R12: dword with sof is not consumed
        @(negedge clk);
        sof = 1'b1; dv = 1'b1; data = 32'hA1A2A3A4;
        @(negedge clk);
        sof = 1'b0; dv = 1'b0;
        eof = 1'b1;
        @(negedge clk);
        eof = 1'b0;
        chk("R12 dword with sof ignored", 32'(match), 32'h0);

        // R12: dword with eof is not consumed
        @(negedge clk);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        dv = 1'b1; data = 32'hA1A2A3A4; eof = 1'b1;
        @(negedge clk);
        dv = 1'b0; eof = 1'b0;
        chk("R12 dword with eof ignored", 32'(match), 32'h0);

        // R11: idle cycles between dwords
        send_frame(3, {32'h0, 32'h0, 32'hDEAD3344, 32'h55FFFFFF, 32'h11112222}, 1'b1);
        chk("R11 gaps ignored", 32'(match), 32'h06);

        // R11: trailing dwords after the closing entry
        send_frame(5, {32'h00000000, 32'hFFFFFFFF, 32'h12345678, 32'h00000000, 32'hA1A2A3A4}, 1'b0);
        chk("R11 trailing dwords", 32'(match), 32'h01);

        // R7: early failure stays failed although later dword fits
        send_frame(2, {32'h0, 32'h0, 32'h0, 32'h99999999, 32'h11112223}, 1'b0);
        chk("R7 miss is sticky", 32'(match), 32'h00);

        // R14 / R9: enable only pattern 4 (shares entry 2 with pattern 0)
        wr(6'd0, 40'h07_05_03_02_10);
        send_frame(1, {32'h0, 32'h0, 32'h0, 32'h0, 32'hA1A2A3A4}, 1'b0);
        chk("R14 new enables used", 32'(match), 32'h10);

        // R9: all disabled
        wr(6'd0, 40'h07_05_03_02_00);
        send_frame(3, {32'h0, 32'h0, 32'hA1A2A3A4, 32'h55000000, 32'hA1A2A3A4}, 1'b0);
        chk("R9 disabled never match", 32'(match), 32'h00);

        // R13: pointer 64 for pattern 7, beyond depth
        wr(6'd0, 40'h07_05_03_02_80);
        wr(6'd1, 40'h40_01_08_02_00);
        wr(6'd0, 40'h07_05_03_02_C0);
        send_frame(2, {32'h0, 32'h0, 32'h0, 32'h00000000, 32'hA1A2A3A4}, 1'b0);
        chk("R13 bad pointers", 32'(match), 32'h00);

        // R3: pattern 7 pointer moved to entry 2 through the header
        wr(6'd1, 40'h02_01_08_02_00);
        send_frame(1, {32'h0, 32'h0, 32'h0, 32'h0, 32'hA1A2A3A4}, 1'b0);
        chk("R3 pointer field of pattern 7", 32'(match), 32'h80);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule